// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the single atomic-access reservation for one core. A load-linked request marks the cache line that holds its address as reserved. A later store-conditional asks whether that reservation still stands. The block returns a one-cycle verdict that also tells the memory pipeline whether the conditional write may be performed. When the verdict is a failure, software is expected to loop back and retry the load-linked / store-conditional pair.

The reservation lasts only while nothing disturbs the line. It is dropped when the cache reports that the line has been evicted or invalidated. This includes evictions that come only from capacity pressure caused by the core's own traffic, with no other agent ever writing the line. It is also dropped when a plain store from any source hits the line, and when any store-conditional is judged. Lines are compared at a granularity set by a parameter, so offset bits inside a line never take part in the comparison.

Top module: `llsc_monitor`

## Requirements
- R1: After a synchronous active-high reset, `resv_held` is 0 and `sc_resp_valid` and `sc_resp_ok` are 0.
- R2: A load-linked request reserves the line of `ll_addr`, which is `ll_addr[ADDR_W-1:log2(LINE_BYTES)]`. `resv_held` reads 1 from the next cycle. Address bits below the line size are ignored, so a store-conditional to any byte of the reserved line matches.
- R3: A store-conditional passes (`sc_resp_ok`=1) only if a reservation is held and its line equals the line of `sc_addr`. A request to another line, or with no reservation held, fails.
- R4: Every store-conditional gives exactly one verdict. `sc_resp_valid` is high for one cycle, in the cycle after the request. `sc_resp_ok`=0 on a failure means no write may be done, and `sc_resp_ok` is never 1 without `sc_resp_valid`.
- R5: An eviction notice whose line equals the reserved line clears the reservation. A notice for any other line leaves it in place.
- R6: A plain store notice whose address falls in the reserved line clears the reservation. A store to another line leaves it in place.
- R7: Every store-conditional clears the reservation, whether it passes or fails.
- R8: A new load-linked replaces any earlier reservation. Only one line is reserved at a time.
- R9: If an eviction or store to the reserved line arrives in the same cycle as a store-conditional to that line, the store-conditional fails.
- R10: When a load-linked and a store-conditional arrive together, the store-conditional is judged against the earlier reservation and the load-linked installs the new one. A load-linked whose line is evicted or stored to in the same cycle leaves no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_req | input | 1 | Load-linked request this cycle |
| ll_addr | input | ADDR_W | Byte address of the load-linked |
| sc_req | input | 1 | Store-conditional request this cycle |
| sc_addr | input | ADDR_W | Byte address of the store-conditional |
| evict_req | input | 1 | Cache reports a line eviction or invalidation |
| evict_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the evicted line |
| store_seen | input | 1 | A plain store from any source was observed |
| store_addr | input | ADDR_W | Byte address of the observed store |
| sc_resp_valid | output | 1 | Verdict for the store-conditional of the previous cycle |
| sc_resp_ok | output | 1 | Store-conditional passed; the write may proceed |
| resv_held | output | 1 | A reservation is currently held |

## Verification
The bench builds the block with a 12-bit address and 64-byte lines, which leaves six line-address bits. Random traffic is drawn from only four lines with random offsets. This makes same-line collisions between load-linked, store-conditional, eviction and store notices frequent, while byte offsets still differ, so the offset-masking and same-cycle priority cases arise often. Directed sequences ahead of the random phase cover each ordering on its own.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    // Outcome of one store-conditional, kept for readability of the judge.
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_PASS = 2'd1,
        SC_FAIL = 2'd2
    } sc_verdict_e;

    // Why a reservation (existing or just requested) is being disturbed.
    typedef struct packed {
        logic by_evict;
        logic by_store;
    } disturb_t;

    // Indices of the line comparators in the top-level probe array.
    localparam int unsigned PRB_SC_RESV = 0;
    localparam int unsigned PRB_EV_RESV = 1;
    localparam int unsigned PRB_ST_RESV = 2;
    localparam int unsigned PRB_EV_LL   = 3;
    localparam int unsigned PRB_ST_LL   = 4;
    localparam int unsigned N_PROBES    = 5;

    function automatic logic disturbed(input disturb_t d);
        return d.by_evict | d.by_store;
    endfunction

endpackage

// File: rtl/llsc_line_match.sv
module llsc_line_match #(
    parameter int unsigned LINE_W = 26
) (
    input  logic              en,
    input  logic [LINE_W-1:0] line_a,
    input  logic [LINE_W-1:0] line_b,
    output logic              hit
);
    always_comb hit = en && (line_a == line_b);
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
    parameter int unsigned LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ll_req,
    input  logic [LINE_W-1:0] ll_line,
    input  logic              ll_blocked,
    input  logic              drop,
    output logic              held,
    output logic [LINE_W-1:0] line
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            line <= '0;
        end else if (ll_req) begin
            held <= !ll_blocked;
            line <= ll_line;
        end else if (drop) begin
            held <= 1'b0;
        end
    end

    // R2
    ll_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (ll_req && !ll_blocked) |=> (held && line == $past(ll_line)));

    // R7
    drop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (drop && !ll_req) |=> !held);

    // R10
    ll_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (ll_req && ll_blocked) |=> !held);
endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge
    import llsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sc_req,
    input  logic     held,
    input  logic     line_hit,
    input  disturb_t kill,
    output logic     resp_valid,
    output logic     resp_ok
);
    sc_verdict_e verdict;

    always_comb begin
        if (!sc_req)
            verdict = SC_IDLE;
        else if (held && line_hit && !disturbed(kill))
            verdict = SC_PASS;
        else
            verdict = SC_FAIL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_ok    <= 1'b0;
        end else begin
            resp_valid <= (verdict != SC_IDLE);
            resp_ok    <= (verdict == SC_PASS);
        end
    end

    // R4
    one_resp_chk: assert property (@(posedge clk) disable iff (rst)
        sc_req |=> resp_valid);

    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !sc_req |=> (!resp_valid && !resp_ok));

    // R3
    no_resv_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (sc_req && !held) |=> !resp_ok);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 64,
    localparam int unsigned OFFS_W    = $clog2(LINE_BYTES),
    localparam int unsigned LINE_W    = ADDR_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ll_req,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              evict_req,
    input  logic [LINE_W-1:0] evict_line,
    input  logic              store_seen,
    input  logic [ADDR_W-1:0] store_addr,
    output logic              sc_resp_valid,
    output logic              sc_resp_ok,
    output logic              resv_held
);
    logic [LINE_W-1:0] ll_line, sc_line, st_line, resv_line;
    logic              held;

    always_comb begin
        ll_line = ll_addr[ADDR_W-1:OFFS_W];
        sc_line = sc_addr[ADDR_W-1:OFFS_W];
        st_line = store_addr[ADDR_W-1:OFFS_W];
    end

    // Probe table: each comparator gets an enable and two lines.
    logic [N_PROBES-1:0]             prb_en;
    logic [N_PROBES-1:0][LINE_W-1:0] prb_a, prb_b;
    logic [N_PROBES-1:0]             prb_hit;

    always_comb begin
        prb_en[PRB_SC_RESV] = sc_req;      prb_a[PRB_SC_RESV] = sc_line;    prb_b[PRB_SC_RESV] = resv_line;
        prb_en[PRB_EV_RESV] = evict_req;   prb_a[PRB_EV_RESV] = evict_line; prb_b[PRB_EV_RESV] = resv_line;
        prb_en[PRB_ST_RESV] = store_seen;  prb_a[PRB_ST_RESV] = st_line;    prb_b[PRB_ST_RESV] = resv_line;
        prb_en[PRB_EV_LL]   = evict_req;   prb_a[PRB_EV_LL]   = evict_line; prb_b[PRB_EV_LL]   = ll_line;
        prb_en[PRB_ST_LL]   = store_seen;  prb_a[PRB_ST_LL]   = st_line;    prb_b[PRB_ST_LL]   = ll_line;
    end

    for (genvar p = 0; p < N_PROBES; p++) begin : g_probe
        llsc_line_match #(.LINE_W(LINE_W)) u_match (
            .en     (prb_en[p]),
            .line_a (prb_a[p]),
            .line_b (prb_b[p]),
            .hit    (prb_hit[p])
        );
    end

    disturb_t kill_resv, kill_ll;
    always_comb begin
        kill_resv.by_evict = held && prb_hit[PRB_EV_RESV];
        kill_resv.by_store = held && prb_hit[PRB_ST_RESV];
        kill_ll.by_evict   = prb_hit[PRB_EV_LL];
        kill_ll.by_store   = prb_hit[PRB_ST_LL];
    end

    llsc_resv_reg #(.LINE_W(LINE_W)) u_resv (
        .clk        (clk),
        .rst        (rst),
        .ll_req     (ll_req),
        .ll_line    (ll_line),
        .ll_blocked (disturbed(kill_ll)),
        .drop       (sc_req || disturbed(kill_resv)),
        .held       (held),
        .line       (resv_line)
    );

    llsc_sc_judge u_judge (
        .clk        (clk),
        .rst        (rst),
        .sc_req     (sc_req),
        .held       (held),
        .line_hit   (prb_hit[PRB_SC_RESV]),
        .kill       (kill_resv),
        .resp_valid (sc_resp_valid),
        .resp_ok    (sc_resp_ok)
    );

    always_comb resv_held = held;

    // R9
    evict_beats_sc_chk: assert property (@(posedge clk) disable iff (rst)
        (sc_req && evict_req && evict_line == sc_line) |=> !sc_resp_ok);

    // R5
    evict_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (evict_req && !ll_req && evict_line == resv_line) |=> !resv_held);

    // R6
    store_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (store_seen && !ll_req && st_line == resv_line) |=> !resv_held);
endmodule

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb;
    localparam int unsigned AW  = 12;
    localparam int unsigned LB  = 64;
    localparam int unsigned OW  = 6;
    localparam int unsigned LW  = AW - OW;

    logic          clk = 1'b0;
    logic          rst;
    logic          ll_req, sc_req, evict_req, store_seen;
    logic [AW-1:0] ll_addr, sc_addr, store_addr;
    logic [LW-1:0] evict_line;
    logic          sc_resp_valid, sc_resp_ok, resv_held;

    always #2.5 clk = ~clk;

    llsc_monitor #(.ADDR_W(AW), .LINE_BYTES(LB)) u_dut (
        .clk, .rst, .ll_req, .ll_addr, .sc_req, .sc_addr,
        .evict_req, .evict_line, .store_seen, .store_addr,
        .sc_resp_valid, .sc_resp_ok, .resv_held
    );

    int n_vec = 0;
    int n_bad = 0;

    // Behavioural reference state.
    bit m_rv;
    int m_line;
    bit e_valid, e_ok, e_held;

    task automatic check1(string req, string what, bit act, bit exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare(string req);
        check1(req, "sc_resp_valid", sc_resp_valid, e_valid);
        check1(req, "sc_resp_ok", sc_resp_ok, e_ok);
        check1(req, "resv_held", resv_held, e_held);
    endtask

    // Drive one cycle of stimulus at the negedge, after checking the
    // outputs produced by the previous cycle's stimulus.
    task automatic step(string req, bit ll, int lla, bit sc, int sca,
                        bit ev, int evl, bit st, int sta);
        int ll_l, sc_l, st_l;
        bit kill_old, kill_new, pass;
        @(negedge clk);
        compare(req);
        ll_req = ll; ll_addr = AW'(lla);
        sc_req = sc; sc_addr = AW'(sca);
        evict_req = ev; evict_line = LW'(evl);
        store_seen = st; store_addr = AW'(sta);
        ll_l = (lla >> OW) & ((1 << LW) - 1);
        sc_l = (sca >> OW) & ((1 << LW) - 1);
        st_l = (sta >> OW) & ((1 << LW) - 1);
        kill_old = m_rv && ((ev && evl == m_line) || (st && st_l == m_line));
        kill_new = (ev && evl == ll_l) || (st && st_l == ll_l);
        pass = sc && m_rv && (m_line == sc_l) && !kill_old;
        e_valid = sc;
        e_ok = pass;
        if (ll) begin
            m_line = ll_l;
            m_rv = !kill_new;
        end else begin
            m_rv = m_rv && !sc && !kill_old;
        end
        e_held = m_rv;
    endtask

    task automatic idle(string req);
        step(req, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(5ns * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ll_req = 0; sc_req = 0; evict_req = 0; store_seen = 0;
        ll_addr = '0; sc_addr = '0; evict_line = '0; store_addr = '0;
        m_rv = 0; m_line = 0; e_valid = 0; e_ok = 0; e_held = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle("R1");
        idle("R1");

        // R2: reserve line 5, conditional to another byte in the same line passes.
        step("R2", 1, 'h140, 0, 0, 0, 0, 0, 0);
        step("R2", 0, 0, 1, 'h17f, 0, 0, 0, 0);
        idle("R2");
        // R7: a second conditional with nothing reserved fails.
        step("R7", 0, 0, 1, 'h140, 0, 0, 0, 0);
        idle("R7");
        // R3: conditional to a different line fails.
        step("R3", 1, 'h140, 0, 0, 0, 0, 0, 0);
        step("R3", 0, 0, 1, 'h180, 0, 0, 0, 0);
        idle("R4");
        // R5: eviction of another line keeps it, of this line drops it.
        step("R5", 1, 'h200, 0, 0, 0, 0, 0, 0);
        step("R5", 0, 0, 0, 0, 1, 9, 0, 0);
        step("R5", 0, 0, 0, 0, 1, 8, 0, 0);
        step("R5", 0, 0, 1, 'h200, 0, 0, 0, 0);
        idle("R4");
        // R6: store elsewhere keeps, store into line drops.
        step("R6", 1, 'h0c4, 0, 0, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0, 0, 1, 'h100);
        step("R6", 0, 0, 0, 0, 0, 0, 1, 'h0fc);
        step("R6", 0, 0, 1, 'h0c4, 0, 0, 0, 0);
        idle("R6");
        // R8: second load-linked replaces the first.
        step("R8", 1, 'h040, 0, 0, 0, 0, 0, 0);
        step("R8", 1, 'h080, 0, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 1, 'h040, 0, 0, 0, 0);
        step("R8", 1, 'h040, 0, 0, 0, 0, 0, 0);
        step("R8", 1, 'h080, 0, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 1, 'h088, 0, 0, 0, 0);
        idle("R8");
        // R9: eviction in the same cycle as the conditional wins.
        step("R9", 1, 'h300, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 1, 'h300, 1, 12, 0, 0);
        idle("R9");
        // R10: load-linked with conditional; load-linked with eviction.
        step("R10", 1, 'h300, 0, 0, 0, 0, 0, 0);
        step("R10", 1, 'h400, 1, 'h300, 0, 0, 0, 0);
        step("R10", 0, 0, 1, 'h400, 0, 0, 0, 0);
        step("R10", 1, 'h400, 0, 0, 1, 16, 0, 0);
        step("R10", 0, 0, 1, 'h400, 0, 0, 0, 0);
        idle("R10");

        // Random phase across four lines.
        for (int i = 0; i < 4000; i++) begin
            bit ll = ($urandom % 4) == 0;
            bit sc = ($urandom % 4) == 0;
            bit ev = ($urandom % 6) == 0;
            bit st = ($urandom % 6) == 0;
            int la = (($urandom % 4) << OW) | ($urandom % LB);
            int sa = (($urandom % 4) << OW) | ($urandom % LB);
            int ta = (($urandom % 4) << OW) | ($urandom % LB);
            int el = $urandom % 4;
            step("R3/R5/R6/R7 random", ll, la, sc, sa, ev, el, st, ta);
        end
        idle("R4");
        idle("R4");

        // R1: reset mid-reservation returns everything to idle.
        step("R1", 1, 'h040, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare("R1");
        rst = 1'b1;
        ll_req = 0;
        @(negedge clk);
        rst = 1'b0;
        m_rv = 0; e_valid = 0; e_ok = 0; e_held = 0;
        idle("R1");
        idle("R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule